// File: doc/BRIEF.md
# Little-Endian Load/Store Access Unit

This block connects a 64-bit integer core to a byte-addressed data memory that is one doubleword wide and only accepts doubleword-aligned addresses. The core hands it one request at a time. A request carries a base register value, a 12-bit signed offset delivered as an upper piece and a lower piece, an access size, an unsigned flag and store data. The unit adds base and offset to form the effective address. It then reads or writes the addressed bytes in little-endian order, least-significant byte at the lowest address. For a load it returns a 64-bit result that is sign-extended or zero-extended.

An access may start at any byte. When its bytes run past the end of the current doubleword, the unit issues a second memory beat to the following doubleword. On a store, that second beat carries the remaining byte enables. On a load, the two read words are merged before extension. A ready signal holds off the next request while an access is in flight, and a one-cycle done pulse marks completion.

Top module: `ldst_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, and `done` and `mem_en` are 0.
- R2: The effective address is `req_base` plus the sign-extended 12-bit offset `{req_off_hi, req_off_lo}` (upper piece is bits 11:5, lower piece is bits 4:0, range -2048 to 2047). The first beat addresses the effective address with its low 3 bits cleared.
- R3: Every beat presents a doubleword-aligned `mem_addr` (low 3 bits zero), and `mem_we` is never high without `mem_en`.
- R4: A store writes byte k of `req_wdata` (bits 8k+7:8k) to byte address EA+k, for k below the access size. `mem_be` bit j enables byte lane j, which is address `mem_addr`+j. Only those bytes are enabled.
- R5: A load returns, in its low bytes, byte EA+k in result byte k (little endian).
- R6: Size codes are 0 byte, 1 halfword, 2 word, 3 doubleword. A signed load (`req_unsigned`=0) copies the top bit of the loaded size into all higher result bits.
- R7: An unsigned load fills the result bits above the loaded size with zeros. For a doubleword the flag has no effect.
- R8: When (EA mod 8) plus the size in bytes exceeds 8, the access uses two beats in consecutive cycles. The second beat goes to the first beat's address plus 8, and the two beats' byte enables are disjoint. Otherwise exactly one beat is issued.
- R9: `done` is a one-cycle pulse. It is high 2 cycles after the accepting clock edge for a one-beat access and 3 cycles after it for a two-beat access. For a load, `rdata` holds the result while `done` is high.
- R10: `req_ready` drops in the cycle after a request is accepted and stays low until the `done` cycle. A request presented while `req_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_unsigned | input | 1 | Zero-extend load result |
| req_base | input | 64 | Base register value |
| req_off_hi | input | 7 | Offset bits 11:5 |
| req_off_lo | input | 5 | Offset bits 4:0 |
| req_wdata | input | 64 | Store data, right-justified |
| mem_en | output | 1 | Memory beat active |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 64 | Doubleword-aligned byte address |
| mem_be | output | 8 | Byte-lane enables for writes |
| mem_wdata | output | 64 | Lane-aligned write data |
| mem_rdata | input | 64 | Read data, valid one cycle after the beat |
| done | output | 1 | Access complete pulse |
| rdata | output | 64 | Extended load result |

## Verification
Counted from the edge that accepts a request, the first memory beat is visible one cycle later. A second beat, when present, follows in the next cycle. `done` with load data arrives two cycles after acceptance for one beat and three cycles after it for two. The bench drives inputs on falling edges and, after the accepting rising edge, counts falling edges until `done` appears. It compares that count with 3 or 4 and only then reads `rdata`. Beat addresses and enables are captured on every rising edge where `mem_en` is high, and the bench's byte-level memory image is compared with a reference byte array after each store. Together these tie each result to the cycle in which it is due.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BEAT0,
    ST_BEAT1,
    ST_RESP
  } state_e;
endpackage

// File: rtl/ldst_agen.sv
// Effective address and beat planning.
module ldst_agen #(
  parameter int XLEN     = 64,
  parameter int OFF_W    = 12,
  parameter int OFF_LO_W = 5
) (
  input  logic [XLEN-1:0]                 base,
  input  logic [OFF_W-OFF_LO_W-1:0]       off_hi,
  input  logic [OFF_LO_W-1:0]             off_lo,
  input  logic [1:0]                      size,
  output logic [$clog2(XLEN/8)-1:0]       lane,
  output logic [XLEN-1:0]                 dw0,
  output logic [XLEN-1:0]                 dw1,
  output logic                            split
);
  localparam int NB     = XLEN / 8;
  localparam int LANE_W = $clog2(NB);
  localparam int CW     = LANE_W + 2;

  logic [OFF_W-1:0] off;
  logic [XLEN-1:0]  off_ext;
  logic [XLEN-1:0]  ea;
  logic [CW-1:0]    nbytes;
  logic [CW-1:0]    last;

  always_comb begin
    off     = {off_hi, off_lo};
    off_ext = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
    ea      = base + off_ext;
    lane    = ea[LANE_W-1:0];
    dw0     = {ea[XLEN-1:LANE_W], {LANE_W{1'b0}}};
    dw1     = dw0 + XLEN'(NB);
    nbytes  = CW'(1) << size;
    last    = {2'b00, lane} + nbytes;
    split   = last > CW'(NB);
  end
endmodule

// File: rtl/ldst_lane_map.sv
// Places store bytes and enables onto the two possible beats.
module ldst_lane_map #(
  parameter int XLEN = 64
) (
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  logic [1:0]                size,
  input  logic [XLEN-1:0]           wdata,
  output logic [XLEN/8-1:0]         be_lo,
  output logic [XLEN/8-1:0]         be_hi,
  output logic [XLEN-1:0]           wd_lo,
  output logic [XLEN-1:0]           wd_hi
);
  localparam int NB     = XLEN / 8;
  localparam int LANE_W = $clog2(NB);
  localparam int CW     = LANE_W + 2;

  logic [CW-1:0]     nbytes;
  logic [NB-1:0]     size_mask;
  logic [2*NB-1:0]   be_wide;
  logic [2*XLEN-1:0] wd_wide;

  assign nbytes = CW'(1) << size;

  for (genvar i = 0; i < NB; i++) begin : g_mask
    assign size_mask[i] = CW'(i) < nbytes;
  end

  always_comb begin
    be_wide = {{NB{1'b0}}, size_mask} << lane;
    wd_wide = {{XLEN{1'b0}}, wdata} << {lane, 3'b000};
    be_lo   = be_wide[NB-1:0];
    be_hi   = be_wide[2*NB-1:NB];
    wd_lo   = wd_wide[XLEN-1:0];
    wd_hi   = wd_wide[2*XLEN-1:XLEN];
  end
endmodule

// File: rtl/ldst_load_fmt.sv
// Merges one or two read words, aligns the addressed bytes and extends.
module ldst_load_fmt
  import ldst_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]           beat_lo,
  input  logic [XLEN-1:0]           beat_hi,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  logic [1:0]                size,
  input  logic                      uns,
  output logic [XLEN-1:0]           result
);
  localparam int NB     = XLEN / 8;
  localparam int LANE_W = $clog2(NB);
  localparam int CW     = LANE_W + 2;

  logic [XLEN-1:0] raw;
  logic [CW-1:0]   nbytes;
  logic            sign;
  logic [7:0]      fill;

  always_comb begin
    raw    = XLEN'({beat_hi, beat_lo} >> {lane, 3'b000});
    nbytes = CW'(1) << size;
    case (size)
      SZ_B:    sign = raw[7];
      SZ_H:    sign = raw[15];
      SZ_W:    sign = raw[31];
      default: sign = raw[XLEN-1];
    endcase
    fill = (uns ? 1'b0 : sign) ? 8'hFF : 8'h00;
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign result[8*i +: 8] = (CW'(i) < nbytes) ? raw[8*i +: 8] : fill;
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int OFF_W    = 12,
  parameter int OFF_LO_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_store,
  input  logic [1:0]                  req_size,
  input  logic                        req_unsigned,
  input  logic [XLEN-1:0]             req_base,
  input  logic [OFF_W-OFF_LO_W-1:0]   req_off_hi,
  input  logic [OFF_LO_W-1:0]         req_off_lo,
  input  logic [XLEN-1:0]             req_wdata,
  output logic                        mem_en,
  output logic                        mem_we,
  output logic [XLEN-1:0]             mem_addr,
  output logic [XLEN/8-1:0]           mem_be,
  output logic [XLEN-1:0]             mem_wdata,
  input  logic [XLEN-1:0]             mem_rdata,
  output logic                        done,
  output logic [XLEN-1:0]             rdata
);
  localparam int NB     = XLEN / 8;
  localparam int LANE_W = $clog2(NB);

  state_e state;

  // request plan, combinational from the live request
  logic [LANE_W-1:0] a_lane;
  logic [XLEN-1:0]   a_dw0, a_dw1;
  logic              a_split;
  logic [NB-1:0]     m_be_lo, m_be_hi;
  logic [XLEN-1:0]   m_wd_lo, m_wd_hi;

  // held request state
  logic [LANE_W-1:0] lane_q;
  logic [1:0]        size_q;
  logic              uns_q;
  logic              split_q;
  logic              store_q;
  logic [XLEN-1:0]   dw1_q;
  logic [NB-1:0]     be_hi_q;
  logic [XLEN-1:0]   wd_hi_q;
  logic [XLEN-1:0]   lo_q;

  logic [XLEN-1:0]   f_lo;
  logic [XLEN-1:0]   f_result;

  ldst_agen #(.XLEN(XLEN), .OFF_W(OFF_W), .OFF_LO_W(OFF_LO_W)) u_agen (
    .base   (req_base),
    .off_hi (req_off_hi),
    .off_lo (req_off_lo),
    .size   (req_size),
    .lane   (a_lane),
    .dw0    (a_dw0),
    .dw1    (a_dw1),
    .split  (a_split)
  );

  ldst_lane_map #(.XLEN(XLEN)) u_map (
    .lane  (a_lane),
    .size  (req_size),
    .wdata (req_wdata),
    .be_lo (m_be_lo),
    .be_hi (m_be_hi),
    .wd_lo (m_wd_lo),
    .wd_hi (m_wd_hi)
  );

  // first beat's read word is parked in lo_q only when a second beat follows
  assign f_lo = split_q ? lo_q : mem_rdata;

  ldst_load_fmt #(.XLEN(XLEN)) u_fmt (
    .beat_lo (f_lo),
    .beat_hi (mem_rdata),
    .lane    (lane_q),
    .size    (size_q),
    .uns     (uns_q),
    .result  (f_result)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
      lane_q    <= '0;
      size_q    <= '0;
      uns_q     <= 1'b0;
      split_q   <= 1'b0;
      store_q   <= 1'b0;
      dw1_q     <= '0;
      be_hi_q   <= '0;
      wd_hi_q   <= '0;
      lo_q      <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mem_en    <= 1'b1;
            mem_we    <= req_store;
            mem_addr  <= a_dw0;
            mem_be    <= m_be_lo;
            mem_wdata <= m_wd_lo;
            lane_q    <= a_lane;
            size_q    <= req_size;
            uns_q     <= req_unsigned;
            split_q   <= a_split;
            store_q   <= req_store;
            dw1_q     <= a_dw1;
            be_hi_q   <= m_be_hi;
            wd_hi_q   <= m_wd_hi;
            state     <= ST_BEAT0;
          end
        end
        ST_BEAT0: begin
          if (split_q) begin
            mem_addr  <= dw1_q;
            mem_be    <= be_hi_q;
            mem_wdata <= wd_hi_q;
            state     <= ST_BEAT1;
          end else begin
            mem_en <= 1'b0;
            mem_we <= 1'b0;
            state  <= ST_RESP;
          end
        end
        ST_BEAT1: begin
          mem_en <= 1'b0;
          mem_we <= 1'b0;
          lo_q   <= mem_rdata;
          state  <= ST_RESP;
        end
        default: begin
          if (!store_q) rdata <= f_result;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk #(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_en,
  input logic              mem_we,
  input logic [XLEN-1:0]   mem_addr,
  input logic [XLEN/8-1:0] mem_be,
  input logic              done
);
  localparam int NB     = XLEN / 8;
  localparam int LANE_W = $clog2(NB);

  AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (mem_addr[LANE_W-1:0] == '0)); // R3
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en); // R3
  AST_BEAT_HAS_LANES: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (mem_be != '0)); // R4
  AST_SECOND_BEAT_NEXT_DW: assert property (@(posedge clk) disable iff (rst)
    (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + XLEN'(NB))); // R8
  AST_SECOND_BEAT_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    (mem_en && $past(mem_en)) |-> ((mem_be & $past(mem_be)) == '0)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R10
endmodule

bind ldst_unit ldst_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .done      (done)
);

// File: tb/tb_ldst_unit.sv
`timescale 1ns/1ps
module tb_ldst_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_unsigned = 1'b0;
  logic [63:0] req_base = '0;
  logic [6:0]  req_off_hi = '0;
  logic [4:0]  req_off_lo = '0;
  logic [63:0] req_wdata = '0;
  logic        mem_en, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic [7:0]  mem_be;
  logic [63:0] mem_rdata = '0;
  logic        done;
  logic [63:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ldst_unit dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_off_hi(req_off_hi), .req_off_lo(req_off_lo), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .rdata(rdata)
  );

  // bench memory (16 doublewords) and reference byte image
  logic [63:0] tmem [16];
  logic [7:0]  refb [128];
  int          beat_n, we_n;
  logic [63:0] b_addr [2];
  logic [7:0]  b_be [2];

  always @(posedge clk) begin
    if (mem_en) begin
      if (beat_n < 2) begin
        b_addr[beat_n] <= mem_addr;
        b_be[beat_n]   <= mem_be;
      end
      beat_n <= beat_n + 1;
      if (mem_we) begin
        we_n <= we_n + 1;
        for (int j = 0; j < 8; j++)
          if (mem_be[j]) tmem[mem_addr[6:3]][8*j +: 8] <= mem_wdata[8*j +: 8];
      end else begin
        mem_rdata <= tmem[mem_addr[6:3]];
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_load(input int ea, input int size, input bit uns);
    logic [63:0] v = '0;
    int nb = 1 << size;
    for (int k = 0; k < nb; k++) v[8*k +: 8] = refb[(ea + k) % 128];
    if (!uns && nb < 8 && v[8*nb-1])
      for (int k = nb; k < 8; k++) v[8*k +: 8] = 8'hFF;
    return v;
  endfunction

  task automatic check_image(input string req);
    int bad = 0;
    for (int i = 0; i < 128; i++)
      if (tmem[i/8][8*(i%8) +: 8] !== refb[i]) bad++;
    check(req, 64'(bad), 64'd0);
  endtask

  // one request; returns result and falling edges from accept to done
  task automatic access(input bit st, input int size, input bit uns, input logic [63:0] base,
                        input int off, input logic [63:0] wd,
                        output logic [63:0] res, output int lat);
    logic [11:0] o12 = off[11:0];
    @(negedge clk);
    beat_n = 0; we_n = 0;
    req_store = st; req_size = size[1:0]; req_unsigned = uns; req_base = base;
    req_off_hi = o12[11:5]; req_off_lo = o12[4:0]; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    res = rdata;
    if (st) begin
      int ea = int'(base + 64'(signed'(o12)));
      for (int k = 0; k < (1 << size); k++) refb[(ea + k) % 128] = wd[8*k +: 8];
    end
  endtask

  task automatic t_reset();
    check("R1 ready", 64'(req_ready), 64'd1);
    check("R1 done", 64'(done), 64'd0);
    check("R1 mem_en", 64'(mem_en), 64'd0);
  endtask

  task automatic t_dword_aligned();
    logic [63:0] r; int lat;
    access(1, 3, 0, 64'd32, 8, 64'h0123_4567_89AB_CDEF, r, lat);
    check("R2 beat addr", b_addr[0], 64'd40);
    check("R4 enables", 64'(b_be[0]), 64'hFF);
    check("R8 one beat", 64'(beat_n), 64'd1);
    check("R9 store latency", 64'(lat), 64'd3);
    check_image("R4 image");
    access(0, 3, 0, 64'd40, 0, '0, r, lat);
    check("R5 dword load", r, 64'h0123_4567_89AB_CDEF);
    check("R9 load latency", 64'(lat), 64'd3);
  endtask

  task automatic t_offsets();
    logic [63:0] r; int lat;
    access(1, 2, 0, 64'd100, -44, 64'h1111_2222_DEAD_BEEF, r, lat);
    check("R2 negative offset addr", b_addr[0], 64'd56);
    check("R4 word enables", 64'(b_be[0]), 64'h0F);
    check_image("R4 word image");
    access(0, 0, 1, -64'd2000, 2047, '0, r, lat);
    check("R2 max offset addr", b_addr[0], 64'd40);
    check("R2 max offset data", r, exp_load(47, 0, 1));
    access(0, 0, 1, 64'd2064, -2048, '0, r, lat);
    check("R2 min offset addr", b_addr[0], 64'd16);
  endtask

  task automatic t_extension();
    logic [63:0] r; int lat;
    access(1, 0, 0, 64'd3, 0, 64'h55F7, r, lat);
    check("R4 byte enables", 64'(b_be[0]), 64'h08);
    check_image("R4 byte image");
    access(0, 0, 0, 64'd3, 0, '0, r, lat);
    check("R6 signed byte", r, 64'hFFFF_FFFF_FFFF_FFF7);
    access(0, 0, 1, 64'd3, 0, '0, r, lat);
    check("R7 unsigned byte", r, 64'h0000_0000_0000_00F7);
    access(1, 1, 0, 64'd10, 0, 64'h8001, r, lat);
    access(0, 1, 0, 64'd10, 0, '0, r, lat);
    check("R6 signed half", r, 64'hFFFF_FFFF_FFFF_8001);
    access(1, 2, 0, 64'd20, 0, 64'h8000_0000, r, lat);
    access(0, 2, 0, 64'd20, 0, '0, r, lat);
    check("R6 signed word", r, 64'hFFFF_FFFF_8000_0000);
    access(0, 2, 1, 64'd20, 0, '0, r, lat);
    check("R7 unsigned word", r, 64'h0000_0000_8000_0000);
  endtask

  task automatic t_split();
    logic [63:0] r, r2; int lat;
    access(1, 2, 0, 64'd14, 0, 64'hA1B2_C3D4, r, lat);
    check("R8 two beats", 64'(beat_n), 64'd2);
    check("R8 beat0 addr", b_addr[0], 64'd8);
    check("R8 beat1 addr", b_addr[1], 64'd16);
    check("R8 beat0 enables", 64'(b_be[0]), 64'hC0);
    check("R8 beat1 enables", 64'(b_be[1]), 64'h03);
    check("R9 split store latency", 64'(lat), 64'd4);
    check_image("R4 split image");
    access(0, 2, 1, 64'd14, 0, '0, r, lat);
    check("R5 split word load", r, 64'h0000_0000_A1B2_C3D4);
    check("R9 split load latency", 64'(lat), 64'd4);
    access(1, 1, 0, 64'd7, 0, 64'h1234, r, lat);
    check("R8 half beat0 enables", 64'(b_be[0]), 64'h80);
    check("R8 half beat1 enables", 64'(b_be[1]), 64'h01);
    access(0, 3, 0, 64'd13, 0, '0, r, lat);
    check("R5 split dword load", r, exp_load(13, 3, 0));
    access(0, 3, 1, 64'd13, 0, '0, r2, lat);
    check("R7 dword flag ignored", r2, r);
    access(0, 2, 0, 64'd16, 0, '0, r, lat);
    check("R8 aligned word one beat", 64'(beat_n), 64'd1);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] r; int lat;
    @(negedge clk);
    beat_n = 0; we_n = 0;
    req_store = 0; req_size = 2'd3; req_unsigned = 0; req_base = 64'd64;
    req_off_hi = '0; req_off_lo = '0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 busy after accept", 64'(req_ready), 64'd0);
    req_store = 1; req_base = 64'd72; req_wdata = 64'hBAD0_BAD0_BAD0_BAD0;
    @(negedge clk);
    check("R10 still busy", 64'(req_ready), 64'd0);
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 done pulse", 64'(done), 64'd1);
    check("R10 ready with done", 64'(req_ready), 64'd1);
    check("R10 load result", rdata, exp_load(64, 3, 0));
    check("R10 no write beat", 64'(we_n), 64'd0);
    check_image("R10 image unchanged");
    @(negedge clk);
    check("R9 done dropped", 64'(done), 64'd0);
    access(0, 3, 0, 64'd72, 0, '0, r, lat);
    check("R10 ignored store absent", r, exp_load(72, 3, 0));
  endtask

  initial begin
    for (int i = 0; i < 128; i++) refb[i] = 8'(i * 37 + 5);
    for (int w = 0; w < 16; w++)
      for (int k = 0; k < 8; k++) tmem[w][8*k +: 8] = refb[8*w + k];
    beat_n = 0; we_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_dword_aligned();
    t_offsets();
    t_extension();
    t_split();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8ns * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule